// File: doc/BRIEF.md
# Per-Core Timer Bank with Requester Alias Window

This block holds one private countdown timer for each processor core of a cluster, with the number of cores set by a parameter. Software reaches the timers through a word-addressed register space that is cut into equal 32-byte windows. The lowest window is an alias. The same address reaches a different timer depending on which core issues the access, so every core can find its own timer at one fixed address. Each higher window is bound to one core for good, so any core can inspect or program any other core's timer.

Every access carries the requester's core number on a separate input. If an alias access names a core that is not fitted, the block raises an error pulse and returns zero. Windows above the last fitted core read as zero and ignore writes. Each timer drives its own interrupt line, and the lines are packed with core 0 at bit 0. Read data and the error flag are registered, so they appear one cycle after the access.

Each timer offers four word registers. A reload value, a live counter, a control word (run, auto-reload, interrupt enable) and a sticky expiry flag that is cleared by writing a one to it.

Top module: `timer_bank`

## Requirements
- R1: The bank holds NUM_CORES independent timers, with NUM_CORES allowed from 1 to 8 (any other value stops elaboration). A write to one timer leaves every other timer unchanged.
- R2: Only accesses with busSize equal to 2 (4 bytes) and busAddr[1:0] equal to 0 act. Any other access returns zero data, changes nothing and raises no error.
- R3: Window 0 (busAddr bits [8:5] equal to 0) reaches the timer of the core given on coreId.
- R4: Window k+1 (busAddr bits [8:5] equal to k+1) reaches the timer of core k, for k below NUM_CORES.
- R5: irq bit k is high exactly when timer k has its expiry flag set and its control bit 2 (interrupt enable) set.
- R6: Reset clears reload, counter, control and flag in every timer, and drives rdata, accErr and irq to zero.
- R7: A word access through window 0 with coreId at or above NUM_CORES sets accErr for one cycle, returns zero data and changes no timer.
- R8: A word access to a window above NUM_CORES returns zero, changes nothing and leaves accErr low.
- R9: Register word index busAddr[4:2] selects the register. 0 is the reload value, and writing it also loads the counter. 1 is the counter. 2 is the control word, where bit 0 is run, bit 1 is auto-reload and bit 2 is interrupt enable; the other bits are not stored and read as 0. 3 is the status word, where bit 0 is the expiry flag and writing a 1 clears it. Indices 4 to 7 read as zero.
- R10: While run is set and the counter is nonzero, the counter falls by one each cycle. The step from 1 to 0 sets the flag, and with auto-reload set the counter takes the reload value instead of 0. A counter or reload write in the same cycle wins over the step and suppresses the expiry. Expiry wins over a clear in the same cycle.
- R11: rdata and accErr are registered. They reflect an access in the cycle after it and are zero after cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 9 | Byte address: window in [8:5], register word in [4:2] |
| busSize | input | 2 | Access size code, 2 = 32-bit |
| coreId | input | 3 | Number of the requesting core |
| busWdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| accErr | output | 1 | One-cycle error pulse for an alias access from an unfitted core |
| irq | output | NUM_CORES | Per-core interrupt, core 0 at bit 0 |

## Verification
The hardest case to reach from the ports is a collision inside one cycle. This happens when a counter or reload write, or a flag clear, lands in the same cycle that a timer steps from 1 to 0. It is harder still when that write comes through the alias window on behalf of a core other than the one just addressed directly. The stimulus keeps written counter and reload values small, so timers expire every few cycles. It also draws coreId across all eight codes and window numbers above the fitted range, so that alias writes, direct writes, unfitted-core errors and expiries keep overlapping. A cycle-level model in the bench tracks every timer and checks read data, the error pulse and every interrupt line on every cycle.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int MAX_CORES = 8;
  localparam int WIN_BYTES = 32;
  localparam int OFS_W     = $clog2(WIN_BYTES);
  localparam int ADDR_W    = $clog2((MAX_CORES + 1) * WIN_BYTES);
  localparam int WIN_W     = ADDR_W - OFS_W;
  localparam int CID_W     = $clog2(MAX_CORES);
  localparam int REG_W     = OFS_W - 2;

  typedef struct packed {
    logic             hitValid;
    logic [CID_W-1:0] hitIdx;
    logic             wrEn;
    logic             rdEn;
    logic [REG_W-1:0] regIdx;
    logic             errFlag;
  } accStrobe_t;
endpackage

// File: rtl/timer_bank_ctrl.sv
module timer_bank_ctrl
  import timer_bank_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [CID_W-1:0]  coreId,
  output accStrobe_t        strb
);
  localparam logic [CID_W:0]   NC_CID = (CID_W + 1)'(NUM_CORES);
  localparam logic [WIN_W-1:0] NC_WIN = WIN_W'(NUM_CORES);

  logic             wordOk;
  logic [WIN_W-1:0] busWin;
  logic             isAlias;
  logic             aliasOk;
  logic             directOk;

  always_comb begin
    wordOk   = (busSize == 2'd2) && (busAddr[1:0] == 2'b00);
    busWin   = busAddr[ADDR_W-1:OFS_W];
    isAlias  = (busWin == '0);
    aliasOk  = ({1'b0, coreId} < NC_CID);
    directOk = (busWin <= NC_WIN);

    strb.wrEn     = busWrite;
    strb.rdEn     = !busWrite;
    strb.regIdx   = busAddr[OFS_W-1:2];
    strb.hitIdx   = isAlias ? coreId : CID_W'(busWin - 1'b1);
    strb.hitValid = busSel && wordOk && (isAlias ? aliasOk : directOk);
    strb.errFlag  = busSel && wordOk && isAlias && !aliasOk;
  end
endmodule

// File: rtl/timer_bank_core.sv
module timer_bank_core
  import timer_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdWord,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] cnt;
  logic [2:0]        ctrlBits;
  logic              flag;
  logic              wrLoad, wrCnt, wrCtrl, wrStat;
  logic              stepping, expire;

  always_comb begin
    wrLoad   = wrEn && (regIdx == REG_W'(0));
    wrCnt    = wrEn && (regIdx == REG_W'(1));
    wrCtrl   = wrEn && (regIdx == REG_W'(2));
    wrStat   = wrEn && (regIdx == REG_W'(3));
    stepping = ctrlBits[0] && (cnt != '0);
    expire   = ctrlBits[0] && (cnt == ONE) && !wrLoad && !wrCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal  <= '0;
      cnt      <= '0;
      ctrlBits <= '0;
      flag     <= 1'b0;
    end else begin
      if (wrLoad) begin
        loadVal <= wdata;
        cnt     <= wdata;
      end else if (wrCnt) begin
        cnt <= wdata;
      end else if (stepping) begin
        cnt <= (cnt == ONE && ctrlBits[1]) ? loadVal : cnt - ONE;
      end
      if (wrCtrl) ctrlBits <= wdata[2:0];
      if (expire) flag <= 1'b1;
      else if (wrStat && wdata[0]) flag <= 1'b0;
    end
  end

  always_comb begin
    case (regIdx)
      REG_W'(0): rdWord = loadVal;
      REG_W'(1): rdWord = cnt;
      REG_W'(2): rdWord = {{(DATA_W-3){1'b0}}, ctrlBits};
      REG_W'(3): rdWord = {{(DATA_W-1){1'b0}}, flag};
      default:   rdWord = '0;
    endcase
  end

  assign irq = flag && ctrlBits[2];
endmodule

// File: rtl/timer_bank_dp.sv
module timer_bank_dp
  import timer_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  accStrobe_t           strb,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 accErr,
  output logic [NUM_CORES-1:0] irq
);
  logic [DATA_W-1:0] rdWord [NUM_CORES];
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic coreWr;
    assign coreWr = strb.hitValid && strb.wrEn && (strb.hitIdx == CID_W'(g));
    timer_bank_core #(.DATA_W(DATA_W)) i_core (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (coreWr),
      .regIdx (strb.regIdx),
      .wdata  (wdata),
      .rdWord (rdWord[g]),
      .irq    (irq[g])
    );
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (strb.hitIdx == CID_W'(i)) rdMux = rdMux | rdWord[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata  <= '0;
      accErr <= 1'b0;
    end else begin
      rdata  <= (strb.hitValid && strb.rdEn) ? rdMux : '0;
      accErr <= strb.errFlag;
    end
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [1:0]           busSize,
  input  logic [CID_W-1:0]     coreId,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 accErr,
  output logic [NUM_CORES-1:0] irq
);
  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_badCount
    $error("timer_bank: NUM_CORES out of range");
  end

  accStrobe_t strb;

  timer_bank_ctrl #(.NUM_CORES(NUM_CORES)) i_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .coreId   (coreId),
    .strb     (strb)
  );

  timer_bank_dp #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (busWdata),
    .rdata  (rdata),
    .accErr (accErr),
    .irq    (irq)
  );
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk
  import timer_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [1:0]           busSize,
  input logic [CID_W-1:0]     coreId,
  input logic [DATA_W-1:0]    rdata,
  input logic                 accErr,
  input logic [NUM_CORES-1:0] irq
);
  localparam logic [CID_W:0] NC_CID = (CID_W + 1)'(NUM_CORES);

  logic wordOk, inAlias, badCore;
  assign wordOk  = (busSize == 2'd2) && (busAddr[1:0] == 2'b00);
  assign inAlias = (busAddr[ADDR_W-1:OFS_W] == '0);
  assign badCore = ({1'b0, coreId} >= NC_CID);

  a_r7_err_raised: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && wordOk && inAlias && badCore) |=> accErr);

  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (rdata == '0));

  a_r8_direct_no_err: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !inAlias) |=> !accErr);

  a_r2_bad_size_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !wordOk) |=> (!accErr && rdata == '0));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> (!accErr && rdata == '0));

  a_r5_irq_falls_after_write: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |=> ((irq & $past(irq)) == $past(irq)));
endmodule

bind timer_bank timer_bank_chk #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busSize  (busSize),
  .coreId   (coreId),
  .rdata    (rdata),
  .accErr   (accErr),
  .irq      (irq)
);

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
  import timer_bank_pkg::*;
  localparam int NC = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0] busSize = 2'd2;
  logic [CID_W-1:0] coreId = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] rdata;
  logic accErr;
  logic [NC-1:0] irq;

  timer_bank #(.NUM_CORES(NC), .DATA_W(DW)) i_timer_bank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .coreId(coreId),
    .busWdata(busWdata), .rdata(rdata), .accErr(accErr), .irq(irq)
  );

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit started = 0;
  string curTag = "";

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // bench model of every timer
  logic [DW-1:0] mLoad [NC];
  logic [DW-1:0] mCnt  [NC];
  logic [2:0]    mCtrl [NC];
  logic          mFlag [NC];
  bit pend; logic [DW-1:0] eRd; bit eErr; string eTag;
  bit okW, hit, wrThis, cntW, expire;
  int w, r, tgt;

  function automatic logic [DW-1:0] mRead(int c, int rr);
    case (rr)
      0: return mLoad[c];
      1: return mCnt[c];
      2: return {29'd0, mCtrl[c]};
      3: return {31'd0, mFlag[c]};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NC; c++) begin
        mLoad[c] = '0; mCnt[c] = '0; mCtrl[c] = '0; mFlag[c] = 1'b0;
      end
      pend = 0; eRd = '0; eErr = 0; eTag = "R6";
    end else begin
      okW = (busSize == 2'd2) && (busAddr[1:0] == 2'b00);
      w   = int'(busAddr[ADDR_W-1:5]);
      r   = int'(busAddr[4:2]);
      tgt = (w == 0) ? int'(coreId) : w - 1;
      hit = busSel && okW && tgt < NC;
      eErr = busSel && okW && w == 0 && int'(coreId) >= NC;
      eRd = (hit && !busWrite) ? mRead(tgt, r) : '0;
      pend = busSel;
      if (curTag != "") eTag = curTag;
      else if (!okW) eTag = "R2";
      else if (eErr) eTag = "R7";
      else if (w > NC) eTag = "R8";
      else if (w == 0) eTag = "R3";
      else eTag = "R4";
      for (int c = 0; c < NC; c++) begin
        wrThis = hit && busWrite && tgt == c;
        cntW   = wrThis && r <= 1;
        expire = mCtrl[c][0] && mCnt[c] == 1 && !cntW;
        if (wrThis && r == 0) begin mLoad[c] = busWdata; mCnt[c] = busWdata; end
        else if (wrThis && r == 1) mCnt[c] = busWdata;
        else if (mCtrl[c][0] && mCnt[c] != 0)
          mCnt[c] = (mCnt[c] == 1 && mCtrl[c][1]) ? mLoad[c] : mCnt[c] - 1;
        if (wrThis && r == 2) mCtrl[c] = busWdata[2:0];
        if (expire) mFlag[c] = 1'b1;
        else if (wrThis && r == 3 && busWdata[0]) mFlag[c] = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && started) begin
      if (pend) begin
        chk(rdata == eRd, eTag, "rdata", rdata, eRd);
        chk(accErr == eErr, eTag, "accErr", {31'd0, accErr}, {31'd0, eErr});
      end else begin
        chk(rdata == '0 && !accErr, "R11", "idle outputs", rdata, '0);
      end
      for (int c = 0; c < NC; c++)
        chk(irq[c] == (mFlag[c] & mCtrl[c][2]), "R5", $sformatf("irq[%0d]", c),
            {31'd0, irq[c]}, {31'd0, mFlag[c] & mCtrl[c][2]});
    end
  end

  task automatic accFull(bit we, logic [ADDR_W-1:0] a, logic [1:0] sz, int cid, logic [DW-1:0] wd);
    @(negedge clk);
    busSel = 1'b1; busWrite = we; busAddr = a; busSize = sz;
    coreId = CID_W'(cid); busWdata = wd;
  endtask

  task automatic acc(bit we, int win, int rr, logic [DW-1:0] wd, int cid);
    accFull(we, ADDR_W'((win << 5) | (rr << 2)), 2'd2, cid, wd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busSel = 1'b0; busWrite = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(rdata == '0, "R6", "rdata in reset", rdata, '0);
    chk(!accErr, "R6", "accErr in reset", {31'd0, accErr}, '0);
    chk(irq == '0, "R6", "irq in reset", {28'd0, irq}, '0);
    rstN = 1'b1;
    started = 1;

    curTag = "R6";
    for (int k = 0; k < NC; k++) for (int q = 0; q < 4; q++) acc(0, k + 1, q, '0, 0);

    curTag = "R1";
    for (int k = 0; k < NC; k++) acc(1, k + 1, 0, 100 + k, 0);
    for (int k = 0; k < NC; k++) acc(0, k + 1, 0, '0, 0);
    curTag = "R4";
    for (int k = 0; k < NC; k++) acc(0, k + 1, 1, '0, 7);
    curTag = "R3";
    for (int k = 0; k < NC; k++) acc(0, 0, 0, '0, k);
    acc(1, 0, 0, 200, 2);
    acc(0, 3, 0, '0, 0);

    curTag = "R7";
    acc(1, 0, 0, 55, NC);
    acc(0, 0, 0, '0, 7);
    for (int k = 0; k < NC; k++) acc(0, k + 1, 0, '0, 0);

    curTag = "R8";
    acc(1, NC + 1, 0, 77, 0);
    acc(1, 15, 1, 9, 0);
    acc(0, NC + 1, 0, '0, 0);
    for (int k = 0; k < NC; k++) acc(0, k + 1, 0, '0, 0);

    curTag = "R2";
    accFull(1, ADDR_W'(32 + 0), 2'd1, 0, 33);
    accFull(1, ADDR_W'(32 + 1), 2'd2, 0, 34);
    accFull(0, ADDR_W'(32 + 0), 2'd0, 0, 0);
    acc(0, 1, 0, '0, 0);

    curTag = "R9";
    acc(1, 1, 2, 32'hFFFF_FFF8, 0);
    acc(0, 1, 2, '0, 0);
    acc(1, 1, 2, 32'hFFFF_FFFC, 0);
    acc(0, 1, 2, '0, 0);
    acc(0, 1, 4, '0, 0);
    acc(0, 1, 7, '0, 0);
    acc(1, 1, 2, 0, 0);

    curTag = "R10";
    acc(1, 2, 0, 3, 0);
    acc(1, 2, 2, 3, 0);
    idle(10);
    acc(1, 2, 2, 7, 0);
    idle(2);
    acc(1, 2, 3, 1, 0);
    acc(0, 2, 1, '0, 0);
    idle(4);
    acc(1, 3, 0, 2, 0);
    acc(1, 3, 2, 5, 0);
    idle(6);
    acc(0, 3, 1, '0, 0);
    acc(0, 3, 3, '0, 0);
    acc(1, 2, 2, 0, 0);

    curTag = "R11";
    acc(0, 1, 0, '0, 0);
    idle(3);

    curTag = "";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 5 == 0) idle(1);
      else begin
        int win = $urandom % (MAX_CORES + 3);
        int rr = $urandom % 8;
        logic [ADDR_W-1:0] a;
        logic [1:0] sz = 2'd2;
        logic [DW-1:0] wd;
        if ($urandom % 4 != 0) rr = rr % 4;
        a = ADDR_W'((win << 5) | (rr << 2));
        if ($urandom % 16 == 0) a[1:0] = 2'($urandom);
        if ($urandom % 10 == 0) sz = 2'($urandom);
        case (rr)
          0, 1: wd = $urandom % 12;
          2: wd = $urandom % 8;
          3: wd = $urandom % 2;
          default: wd = $urandom;
        endcase
        accFull($urandom % 2 == 1, a, sz, $urandom % 8, wd);
      end
    end
    idle(5);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule